// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in a small on-chip table. Software fills the table with descriptors, programs the index of the ring's first entry, and pulses a kick input to say that new work may exist. The engine reads the descriptor at its current pointer. If software has marked the descriptor as ready, the engine offers a frame request (buffer address, length, CRC-append flag) to the MAC side. It then waits for the MAC's completion and writes the MAC's error and status flags back into the descriptor. It clears the ready bit, which returns the descriptor to software. It raises a transmit event if the descriptor asked for one, then moves to the next descriptor.

A descriptor whose ready bit is clear stops the walk. The engine parks at that index until the next kick. A per-descriptor wrap bit returns the pointer to the ring base, so software chooses how long the ring is at run time. The MAC request is a valid/ready stream. Once `req_valid` is raised, the request and its payload stay unchanged until the cycle in which `req_ready` is high. Completion is a valid/ready transfer as well. `done_ready` is high only while the engine waits for a result, and `done_valid` has no effect at any other time.

Top module: `txring_engine`

## Requirements
- R1: A descriptor is 64 bits wide: length in [63:48], control/status in [47:32], buffer address in [31:0]. A software write of `dw_data` to index `dw_idx` is returned in full on `rd_data` when `rd_idx` selects that index.
- R2: Control bit 15 is the ready bit. After a kick, a descriptor at the pointer with bit 15 set produces exactly one request carrying its address and length, with `req_crc` equal to control bit 10. Its completion clears bit 15 in the table.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_len` and `req_crc` hold. `done_ready` is high only after a request has been accepted. A `done_valid` presented at any other time leaves the table, the event and the walk unchanged.
- R4: On completion, `done_flags[5:0]` = {deferred, no heartbeat, late collision, retry limit, underrun, carrier lost} is written into control bits [9:4] in that order. Control bits 14..10 and 3..0, the length and the address are preserved.
- R5: After completing a descriptor with control bit 13 (wrap) set, the next fetch is at the base index. Otherwise the next fetch is at index+1, and the index rolls over from RING_DEPTH-1 to 0.
- R6: A fetched descriptor with bit 15 clear puts the engine idle without a request and without moving the pointer. The same index is fetched again on the next kick.
- R7: A kick that arrives while a frame is in flight does not disturb that frame or cause a second request for it.
- R8: Completing a descriptor with control bit 12 set sets `evt_txf`. Completing one without bit 12 leaves `evt_txf` unchanged. A high `evt_clr` clears `evt_txf`, and a set in the same cycle wins.
- R9: `start_we` loads `start_idx` as the base index. Wraps use the new base from then on.
- R10: `rst` or `ctl_rst` makes the engine idle, drops any request, clears `evt_txf` and reloads the pointer from the base index (0 after `rst`). `ctl_rst` keeps the table contents.
- R11: Consecutive ready descriptors are processed back to back without further kicks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_rst | input | 1 | Controller reset pulse |
| start_we | input | 1 | Load ring base index |
| start_idx | input | IDX_W | New ring base index |
| kick | input | 1 | Transmit-active write strobe |
| dw_en | input | 1 | Descriptor write enable |
| dw_idx | input | IDX_W | Descriptor write index |
| dw_data | input | 64 | Descriptor write data |
| rd_idx | input | IDX_W | Descriptor read index |
| rd_data | output | 64 | Descriptor read data |
| req_valid | output | 1 | Frame request valid |
| req_ready | input | 1 | MAC accepts request |
| req_addr | output | 32 | Frame buffer address |
| req_len | output | 16 | Frame length |
| req_crc | output | 1 | Ask MAC to append CRC |
| done_valid | input | 1 | MAC completion valid |
| done_ready | output | 1 | Engine awaits completion |
| done_flags | input | 6 | Completion status flags |
| evt_txf | output | 1 | Transmit-frame event |
| evt_clr | input | 1 | Write-one-to-clear of event |
| busy | output | 1 | Engine is not idle |

## Verification
The walk is driven with a single interrupting descriptor whose request is stalled for several cycles, a descriptor without the interrupt or CRC bits, and a wrapped run of three descriptors with a ready entry left behind the wrap. A run that crosses the top index of the table is also driven. Between them, these patterns separate handshake holding, status packing, event gating, wrap-to-base and modulo roll-over. Idle behaviour is probed by setting ready without a kick, presenting a stray completion, and pulsing the controller reset in the middle of a request. A stale pointer or an ignored base shows up there as a wrong or missing request.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int DESC_W = 64;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int CTL_W  = 16;
  localparam int STAT_W = 6;

  localparam int CB_READY   = 15;
  localparam int CB_WRAP    = 13;
  localparam int CB_INTR    = 12;
  localparam int CB_CRC     = 10;
  localparam int CB_STAT_LO = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_REQ,
    ST_WAIT
  } walk_state_e;
endpackage

// File: rtl/txring_dmem.sv
module txring_dmem
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int IDX_W = $clog2(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [DESC_W-1:0] sw_data,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DESC_W-1:0] eng_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DESC_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DESC_W-1:0] rd_b_data
);
  logic [DESC_W-1:0] mem [RING_DEPTH];
  logic              sw_blocked;

  assign sw_blocked = eng_we && (eng_idx == sw_idx);

  always_ff @(posedge clk) begin
    if (sw_we && !sw_blocked) mem[sw_idx] <= sw_data;
    if (eng_we) mem[eng_idx] <= eng_data;
  end

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];

  // Completion hands the descriptor back to software.
  assert_wb_clears_ready_R2: assert property (@(posedge clk) disable iff (rst)
    eng_we |=> !mem[$past(eng_idx)][32+CB_READY]);
endmodule

// File: rtl/txring_evt.sv
module txring_evt (
  input  logic clk,
  input  logic rst,
  input  logic ctl_rst,
  input  logic set,
  input  logic clr,
  output logic evt_q
);
  always_ff @(posedge clk) begin
    if (rst || ctl_rst) evt_q <= 1'b0;
    else if (set)       evt_q <= 1'b1;
    else if (clr)       evt_q <= 1'b0;
  end

  assert_evt_set_R8: assert property (@(posedge clk) disable iff (rst)
    set && !ctl_rst |=> evt_q);
  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    evt_q && !clr && !ctl_rst |=> evt_q);
endmodule

// File: rtl/txring_fsm.sv
module txring_fsm
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int IDX_W = $clog2(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_rst,
  input  logic              kick,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DESC_W-1:0] fetch_desc,
  output logic [IDX_W-1:0]  ptr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_crc,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic [STAT_W-1:0] done_flags,
  output logic              wb_en,
  output logic [DESC_W-1:0] wb_data,
  output logic              evt_set,
  output logic              busy
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RING_DEPTH - 1);

  walk_state_e       state;
  logic [DESC_W-1:0] cur;
  logic              kick_pend;
  logic [CTL_W-1:0]  cur_ctl, new_ctl;
  logic [IDX_W-1:0]  nxt_ptr;

  assign cur_ctl = cur[32 +: CTL_W];

  always_comb begin
    new_ctl = cur_ctl;
    new_ctl[CB_READY] = 1'b0;
    new_ctl[CB_STAT_LO +: STAT_W] = done_flags;
  end

  always_comb begin
    if (cur_ctl[CB_WRAP])     nxt_ptr = base_idx;
    else if (ptr == TOP_IDX)  nxt_ptr = '0;
    else                      nxt_ptr = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_rst) begin
      state     <= ST_IDLE;
      ptr       <= rst ? '0 : base_idx;
      kick_pend <= 1'b0;
      cur       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (kick) state <= ST_FETCH;
        ST_FETCH: begin
          if (fetch_desc[32+CB_READY]) begin
            cur   <= fetch_desc;
            state <= ST_REQ;
          end else if (!(kick || kick_pend)) begin
            state <= ST_IDLE;
          end
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (done_valid) begin
          ptr   <= nxt_ptr;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
      if (state == ST_FETCH)                 kick_pend <= 1'b0;
      else if (kick && state != ST_IDLE)     kick_pend <= 1'b1;
    end
  end

  assign req_valid  = (state == ST_REQ);
  assign req_addr   = cur[ADDR_W-1:0];
  assign req_len    = cur[DESC_W-1 -: LEN_W];
  assign req_crc    = cur_ctl[CB_CRC];
  assign done_ready = (state == ST_WAIT);
  assign wb_en      = done_ready && done_valid;
  assign wb_data    = {cur[DESC_W-1 -: LEN_W], new_ctl, cur[ADDR_W-1:0]};
  assign evt_set    = wb_en && cur_ctl[CB_INTR];
  assign busy       = (state != ST_IDLE);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready && !ctl_rst |=>
      req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_crc));
  assert_req_owned_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> cur_ctl[CB_READY]);
  assert_idle_park_R6: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE && !kick && !ctl_rst |=> state == ST_IDLE && $stable(ptr));
  assert_stray_done_R3: assert property (@(posedge clk) disable iff (rst)
    done_valid && !done_ready && !ctl_rst |=> $stable(ptr));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int IDX_W = $clog2(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_rst,
  input  logic              start_we,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              kick,
  input  logic              dw_en,
  input  logic [IDX_W-1:0]  dw_idx,
  input  logic [63:0]       dw_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [63:0]       rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_addr,
  output logic [15:0]       req_len,
  output logic              req_crc,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic [5:0]        done_flags,
  output logic              evt_txf,
  input  logic              evt_clr,
  output logic              busy
);
  logic [IDX_W-1:0]  base_q;
  logic [IDX_W-1:0]  ptr;
  logic [DESC_W-1:0] fetch_desc, wb_data;
  logic              wb_en, evt_set;

  always_ff @(posedge clk) begin
    if (rst)           base_q <= '0;
    else if (start_we) base_q <= start_idx;
  end

  txring_dmem #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_dmem (
    .clk(clk), .rst(rst),
    .sw_we(dw_en), .sw_idx(dw_idx), .sw_data(dw_data),
    .eng_we(wb_en), .eng_idx(ptr), .eng_data(wb_data),
    .rd_a_idx(rd_idx), .rd_a_data(rd_data),
    .rd_b_idx(ptr), .rd_b_data(fetch_desc)
  );

  txring_fsm #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .ctl_rst(ctl_rst), .kick(kick),
    .base_idx(base_q), .fetch_desc(fetch_desc), .ptr(ptr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_crc(req_crc),
    .done_valid(done_valid), .done_ready(done_ready), .done_flags(done_flags),
    .wb_en(wb_en), .wb_data(wb_data), .evt_set(evt_set), .busy(busy)
  );

  txring_evt u_evt (
    .clk(clk), .rst(rst), .ctl_rst(ctl_rst),
    .set(evt_set), .clr(evt_clr), .evt_q(evt_txf)
  );

  assert_ctlrst_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> !busy && !req_valid && !evt_txf);
endmodule

// File: tb/test_txring_engine.sv
module test_txring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1, ctl_rst = 1'b0, start_we = 1'b0, kick = 1'b0;
  logic [IDX_W-1:0] start_idx = '0, dw_idx = '0, rd_idx = '0;
  logic dw_en = 1'b0;
  logic [63:0] dw_data = '0;
  logic [63:0] rd_data;
  logic req_valid, req_crc, done_ready, evt_txf, busy;
  logic req_ready = 1'b0, done_valid = 1'b0, evt_clr = 1'b0;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic [5:0] done_flags = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_engine #(.RING_DEPTH(8), .IDX_W(IDX_W)) i_txring_engine (
    .clk(clk), .rst(rst), .ctl_rst(ctl_rst), .start_we(start_we),
    .start_idx(start_idx), .kick(kick), .dw_en(dw_en), .dw_idx(dw_idx),
    .dw_data(dw_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_crc(req_crc), .done_valid(done_valid),
    .done_ready(done_ready), .done_flags(done_flags), .evt_txf(evt_txf),
    .evt_clr(evt_clr), .busy(busy)
  );

  function automatic logic [63:0] mk(input logic [15:0] l, input logic [15:0] c,
                                     input logic [31:0] a);
    return {l, c, a};
  endfunction

  function automatic logic [15:0] after_ctl(input logic [15:0] c, input logic [5:0] f);
    return (c & 16'h7C0F) | {6'b0, f, 4'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int i, input logic [63:0] d);
    dw_en = 1'b1; dw_idx = IDX_W'(i); dw_data = d; tick(); dw_en = 1'b0;
  endtask

  task automatic rd(input int i, output logic [63:0] d);
    rd_idx = IDX_W'(i); #1; d = rd_data;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; tick(); kick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && busy; n++) tick();
  endtask

  task automatic no_req(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin tick(); if (req_valid) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic serve(input logic [31:0] ea, input logic [15:0] el, input bit ecrc,
                       input int stall, input logic [5:0] fl, input bit kick_mid,
                       input string tag);
    bit held = 1;
    for (int n = 0; n < 200 && !req_valid; n++) tick();
    chk(req_valid, {tag, " request seen"}, req_valid, 1);
    chk(req_addr == ea, {tag, " addr"}, req_addr, ea);
    chk(req_len == el, {tag, " len"}, req_len, el);
    chk(req_crc == ecrc, {tag, " crc"}, req_crc, ecrc);
    for (int s = 0; s < stall; s++) begin
      kick = kick_mid;
      tick();
      kick = 1'b0;
      if (!req_valid || req_addr != ea || req_len != el || req_crc != ecrc) held = 0;
    end
    if (stall > 0) chk(held, {tag, " R3 hold under back-pressure"}, held, 1);
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    chk(done_ready && !req_valid, {tag, " R3 done_ready after accept"}, done_ready, 1);
    done_valid = 1'b1; done_flags = fl; tick(); done_valid = 1'b0; done_flags = '0;
  endtask

  task automatic t_reset();
    chk(!busy && !req_valid && !done_ready && !evt_txf, "R10 reset state",
        {busy, req_valid, done_ready, evt_txf}, 0);
  endtask

  task automatic t_mem();
    logic [63:0] d;
    wr(3, mk(16'h0123, 16'h0000, 32'hA5A5_0003));
    rd(3, d);
    chk(d == mk(16'h0123, 16'h0000, 32'hA5A5_0003), "R1 write/readback", d,
        mk(16'h0123, 16'h0000, 32'hA5A5_0003));
  endtask

  task automatic t_single();
    logic [63:0] d;
    wr(0, mk(16'd64, 16'h9C00, 32'h1000_0000));
    pulse_kick();
    serve(32'h1000_0000, 16'd64, 1'b1, 3, 6'b100101, 1'b0, "R2 single");
    wait_idle();
    rd(0, d);
    chk(d == mk(16'd64, after_ctl(16'h9C00, 6'b100101), 32'h1000_0000),
        "R4 R2 status write-back", d,
        mk(16'd64, after_ctl(16'h9C00, 6'b100101), 32'h1000_0000));
    chk(evt_txf, "R8 event set", evt_txf, 1);
  endtask

  task automatic t_idle();
    logic [63:0] d;
    no_req(10, "R6 idle after not-ready");
    wr(1, mk(16'd100, 16'h8000, 32'h0000_2000));
    no_req(5, "R6 no request without kick");
    evt_clr = 1'b1; tick(); evt_clr = 1'b0;
    chk(!evt_txf, "R8 event cleared", evt_txf, 0);
    pulse_kick();
    serve(32'h0000_2000, 16'd100, 1'b0, 0, 6'b000000, 1'b0, "R6 refetch");
    wait_idle();
    chk(!evt_txf, "R8 no event without intr bit", evt_txf, 0);
    rd(1, d);
    chk(d[47:32] == 16'h0000, "R2 ready cleared", d[47:32], 0);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    wr(2, mk(16'd20, 16'hA000, 32'h0000_3000));
    wr(3, mk(16'd30, 16'h8000, 32'h0000_3333));
    wr(0, mk(16'd40, 16'h9000, 32'h0000_4000));
    pulse_kick();
    serve(32'h0000_3000, 16'd20, 1'b0, 1, 6'b010010, 1'b0, "R5 wrap first");
    serve(32'h0000_4000, 16'd40, 1'b0, 0, 6'b000000, 1'b0, "R11 R5 after wrap");
    wait_idle();
    rd(3, d);
    chk(d[47:32] == 16'h8000, "R5 entry past wrap untouched", d[47:32], 16'h8000);
    rd(2, d);
    chk(d[47:32] == 16'h2120, "R4 flags packing", d[47:32], 16'h2120);
    chk(evt_txf, "R8 event from intr descriptor", evt_txf, 1);
  endtask

  task automatic t_stray_done();
    logic [63:0] d0, d1;
    rd(1, d0);
    done_valid = 1'b1; done_flags = 6'h3F; tick(); done_valid = 1'b0; done_flags = '0;
    tick();
    rd(1, d1);
    chk(d1 == d0 && !busy && evt_txf, "R3 stray completion ignored", d1, d0);
  endtask

  task automatic t_base();
    start_idx = 3'd6; start_we = 1'b1; tick(); start_we = 1'b0;
    ctl_rst = 1'b1; tick(); ctl_rst = 1'b0;
    chk(!evt_txf && !busy, "R10 ctl_rst clears event", evt_txf, 0);
    wr(6, mk(16'd60, 16'h8000, 32'h0000_6000));
    wr(7, mk(16'd70, 16'h8000, 32'h0000_7000));
    wr(0, mk(16'd80, 16'hA000, 32'h0000_8000));
    pulse_kick();
    serve(32'h0000_6000, 16'd60, 1'b0, 0, 6'b0, 1'b0, "R9 start at base");
    serve(32'h0000_7000, 16'd70, 1'b0, 0, 6'b0, 1'b0, "R11 next");
    serve(32'h0000_8000, 16'd80, 1'b0, 0, 6'b0, 1'b0, "R5 roll-over to 0");
    wait_idle();
    wr(6, mk(16'd61, 16'h8000, 32'h0000_6100));
    pulse_kick();
    serve(32'h0000_6100, 16'd61, 1'b0, 0, 6'b0, 1'b0, "R9 wrap to programmed base");
    wait_idle();
  endtask

  task automatic t_ctlrst_mid();
    logic [63:0] d;
    wr(7, mk(16'd90, 16'h8000, 32'h0000_9000));
    pulse_kick();
    for (int n = 0; n < 50 && !req_valid; n++) tick();
    ctl_rst = 1'b1; tick(); ctl_rst = 1'b0;
    chk(!req_valid && !busy, "R10 ctl_rst drops request", req_valid, 0);
    rd(7, d);
    chk(d[47:32] == 16'h8000, "R10 table kept", d[47:32], 16'h8000);
    pulse_kick();
    no_req(8, "R10 pointer reloaded from base");
  endtask

  task automatic t_kick_busy();
    wr(6, mk(16'd1, 16'h8000, 32'h0000_B000));
    pulse_kick();
    serve(32'h0000_B000, 16'd1, 1'b0, 3, 6'b0, 1'b1, "R7 kick during request");
    serve(32'h0000_9000, 16'd90, 1'b0, 0, 6'b0, 1'b0, "R7 walk continues");
    wait_idle();
    no_req(8, "R7 no duplicate request");
  endtask

  initial begin
    for (int n = 0; n < 20000 && !finished; n++) @(negedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    for (int i = 0; i < 8; i++) wr(i, 64'd0);
    t_mem();
    wr(3, 64'd0);
    t_single();
    t_idle();
    t_wrap();
    t_stray_done();
    t_base();
    t_ctlrst_mid();
    t_kick_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule